// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable slave that behaves like a small three-wire serial EEPROM. A host selects it with chip select, shifts an instruction in on the data input with the shift clock, and collects read data or programming status from the data output. Every instruction starts with a logic 1 start bit, followed by a two-bit opcode and an address. The block supports read with continuous streaming across words, word write, word erase, and instructions that set and clear a programming lock.

The storage is a register array of 16-bit words. An organisation input selects whether the host addresses 16-bit words or 8-bit bytes; in byte mode each storage word holds two bytes. Programming is self-timed: after a write or erase is accepted, the block is busy for a parameterised number of system clock cycles. The host reads that busy state by dropping chip select and raising it again. The pins are oversampled on a fast system clock through a synchroniser, and data out comes with a separate output-enable instead of a tri-state pin.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After chip select rises, zero bits on data in are skipped. The first 1 sampled on a shift clock rising edge is the start bit. It is followed by a two-bit opcode and then the address, both MSB first. The address is WADDR_W bits when org is 1 and WADDR_W+1 bits when org is 0.
- R2: Read (opcode 10) puts a single 0 dummy bit on data out at the rising edge that takes in the last address bit. Each later rising edge shows the next data bit, MSB first. Data out only changes in response to a shift clock rising edge.
- R3: While chip select stays high, a read continues with the next address straight after the last bit of a word, with no dummy bit. The address wraps from the top of the array to 0.
- R4: With org 0, byte address b maps to storage word b>>1. Bit 0 of b equal to 0 selects the low byte (bits 7:0) and equal to 1 selects the high byte. Reads and writes in byte mode use 8 bits.
- R5: After reset, programming is locked, and write and erase instructions change no storage and start no busy period.
- R6: Opcode 00 with the top two address bits at 11 unlocks programming, and with 00 locks it. The unlocked state lasts across transactions until the lock instruction or a reset.
- R7: Write (opcode 01) stores the 16 or 8 data bits that follow the address. Old contents need no prior erase.
- R8: Erase (opcode 11) sets every bit of the addressed word, or byte in byte mode, to 1.
- R9: An accepted write or erase starts a busy period of PROG_CYCLES clock cycles. During that period instructions are ignored.
- R10: If chip select goes low and then rises while busy, data out is enabled and shows 0 until programming ends and then 1. A start bit or chip select low ends this status display. Raising chip select after the busy period has ended shows no status.
- R11: do_oe is 0 whenever chip select is low and whenever no read or status phase is active.
- R12: Reset clears the storage to all zeros, locks programming and disables the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock from the host |
| di | input | 1 | Serial data input |
| org | input | 1 | Word organisation: 1 for 16-bit, 0 for 8-bit |
| do_o | output | 1 | Serial data output value |
| do_oe | output | 1 | Output enable for do_o |

## Verification
The assertions assume that the host pins change slowly compared with clk. Each shift clock phase and each chip select level must last several clock cycles. Chip select must not change in the same synchronised cycle as a shift clock rising edge, and data in must be steady before the shift clock rises. The bench drives every pin on falling clock edges and holds each shift clock phase for eight cycles. It moves chip select only while the shift clock is low and data in has been settled for a full phase. The org input is changed only while chip select is low.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } ee_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } ee_state_e;

  localparam logic [1:0] EXT_UNLOCK = 2'b11;
  localparam logic [1:0] EXT_LOCK   = 2'b00;

  function automatic logic [4:0] data_bits(input logic org16);
    return org16 ? 5'd16 : 5'd8;
  endfunction

  function automatic logic pick_bit(input logic org16, input logic [WORD_W-1:0] w,
                                    input logic hi_lane, input logic [3:0] idx);
    logic [7:0] lane;
    lane = hi_lane ? w[15:8] : w[7:0];
    if (org16) return w[4'd15 - idx];
    return lane[3'd7 - idx[2:0]];
  endfunction
endpackage

// File: rtl/ee_in_sync.sv
module ee_in_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else if (start) left <= CW'(CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);

  a_r9_start_loads_full: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (left == CW'(CYCLES)));
endmodule

// File: rtl/ee_word_store.sv
module ee_word_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    wmask,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DW / 2;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < 2; l++)
        if (wmask[l]) mem[waddr][l*HALF +: HALF] <= wdata[l*HALF +: HALF];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int WADDR_W     = 8,
  parameter int PROG_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  import ee_pkg::*;

  localparam int BA_W = WADDR_W + 1;

  // address arithmetic, kept in functions
  function automatic logic [4:0] addr_bits(input logic o);
    return o ? 5'(WADDR_W) : 5'(WADDR_W + 1);
  endfunction
  function automatic logic [WADDR_W-1:0] word_of(input logic [BA_W-1:0] a, input logic o);
    return o ? a[WADDR_W-1:0] : a[BA_W-1:1];
  endfunction
  function automatic logic lane_of(input logic [BA_W-1:0] a, input logic o);
    return !o && a[0];
  endfunction
  function automatic logic [BA_W-1:0] next_addr(input logic [BA_W-1:0] a, input logic o);
    if (o) return {1'b0, a[WADDR_W-1:0] + 1'b1};
    return a + 1'b1;
  endfunction
  function automatic logic [1:0] ext_code(input logic [BA_W-1:0] a, input logic o);
    return o ? a[WADDR_W-1 -: 2] : a[BA_W-1 -: 2];
  endfunction

  // synchronised pins and events
  logic [2:0] s_lvl, s_rise, s_fall;
  ee_in_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({cs, sk, di}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );
  logic cs_s, di_s, sk_rise, cs_rise, cs_fall, bit_in;
  assign cs_s    = s_lvl[2];
  assign di_s    = s_lvl[0];
  assign sk_rise = s_rise[1];
  assign cs_rise = s_rise[2];
  assign cs_fall = s_fall[2];
  assign bit_in  = cs_s && sk_rise;

  ee_state_e         state;
  ee_op_e            op;
  logic [BA_W-1:0]   addr;
  logic [WORD_W-1:0] wdat;
  logic [4:0]        cnt;
  logic [3:0]        idx;
  logic wr_en, rd_oe, do_rd, st_arm, st_act, busy;

  // decoded instruction events
  logic [BA_W-1:0]   addr_full, addr_full_m;
  logic [WORD_W-1:0] wfull, rword, store_data;
  logic addr_done, data_done;
  logic cmd_read, cmd_erase, cmd_write, cmd_unlock, cmd_lock, prog_start;
  logic [1:0] store_mask;
  logic [WADDR_W-1:0] store_addr;
  logic store_lane;

  assign addr_full   = {addr[BA_W-2:0], di_s};
  assign addr_full_m = org ? {1'b0, addr_full[WADDR_W-1:0]} : addr_full;
  assign wfull       = {wdat[WORD_W-2:0], di_s};

  assign addr_done  = bit_in && (state == ST_ADDR) && (cnt == addr_bits(org) - 5'd1);
  assign data_done  = bit_in && (state == ST_DATA) && (cnt == data_bits(org) - 5'd1);
  assign cmd_read   = addr_done && (op == OP_READ);
  assign cmd_erase  = addr_done && (op == OP_ERASE);
  assign cmd_write  = data_done;
  assign cmd_unlock = addr_done && (op == OP_EXT) && (ext_code(addr_full_m, org) == EXT_UNLOCK);
  assign cmd_lock   = addr_done && (op == OP_EXT) && (ext_code(addr_full_m, org) == EXT_LOCK);
  assign prog_start = (cmd_erase || cmd_write) && wr_en;

  assign store_addr = cmd_erase ? word_of(addr_full_m, org) : word_of(addr, org);
  assign store_lane = cmd_erase ? lane_of(addr_full_m, org) : lane_of(addr, org);
  assign store_mask = org ? 2'b11 : (store_lane ? 2'b10 : 2'b01);
  assign store_data = cmd_erase ? '1 : (org ? wfull : {wfull[7:0], wfull[7:0]});

  ee_word_store #(.AW(WADDR_W), .DW(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(prog_start), .waddr(store_addr),
    .wdata(store_data), .wmask(store_mask),
    .raddr(word_of(addr, org)), .rdata(rword)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op     <= OP_EXT;
      addr   <= '0;
      wdat   <= '0;
      cnt    <= '0;
      idx    <= '0;
      wr_en  <= 1'b0;
      rd_oe  <= 1'b0;
      do_rd  <= 1'b0;
      st_arm <= 1'b0;
      st_act <= 1'b0;
    end else begin
      // status display bookkeeping
      if (prog_start) st_arm <= 1'b1;
      else if (cs_rise) begin
        st_act <= st_arm && busy;
        st_arm <= 1'b0;
      end

      if (cmd_unlock) wr_en <= 1'b1;
      else if (cmd_lock) wr_en <= 1'b0;

      if (cs_fall) begin
        state  <= ST_IDLE;
        rd_oe  <= 1'b0;
        st_act <= 1'b0;
      end else if (bit_in) begin
        unique case (state)
          ST_IDLE: if (di_s && !busy) begin
            state  <= ST_OPC;
            cnt    <= '0;
            st_act <= 1'b0;
          end
          ST_OPC: begin
            op <= ee_op_e'({op[0], di_s});
            if (cnt == 5'd1) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 5'd1;
          end
          ST_ADDR: begin
            if (addr_done) begin
              addr <= addr_full_m;
              cnt  <= '0;
              case (op)
                OP_READ: begin
                  state <= ST_READ;
                  rd_oe <= 1'b1;
                  do_rd <= 1'b0;
                  idx   <= '0;
                end
                OP_WRITE: state <= ST_DATA;
                default:  state <= ST_HOLD;
              endcase
            end else begin
              addr <= addr_full;
              cnt  <= cnt + 5'd1;
            end
          end
          ST_DATA: begin
            wdat <= wfull;
            if (data_done) state <= ST_HOLD;
            else cnt <= cnt + 5'd1;
          end
          ST_READ: begin
            do_rd <= pick_bit(org, rword, lane_of(addr, org), idx);
            if (5'(idx) == data_bits(org) - 5'd1) begin
              idx  <= '0;
              addr <= next_addr(addr, org);
            end else idx <= idx + 4'd1;
          end
          default: ;
        endcase
      end
    end
  end

  assign do_o  = st_act ? !busy : do_rd;
  assign do_oe = rd_oe || st_act;

  // assertions
  a_r11_off_after_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !do_oe);
  a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && st_act));
  a_r5_prog_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wr_en);
  a_r9_no_prog_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_start);
  a_r2_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> !do_o);
  a_r10_status_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_act) |-> busy);
  a_r6_lock_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> $past(cmd_lock));
  a_r2_read_out_on_sk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && !st_act && $past(rd_oe) && !$past(bit_in)) |-> $stable(do_o));
endmodule

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;
  localparam int PROG = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.WADDR_W(8), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] model [256];
  bit model_we = 0;

  // scoreboard
  bit    exp_val[$];
  string exp_tag[$];
  logic  obs_v, obs_oe;
  logic  mon_pulse = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge mon_pulse) begin
    if (exp_val.size() == 0) chk(0, "R2 unexpected sample", obs_v, 0);
    else begin
      automatic bit    e = exp_val.pop_front();
      automatic string t = exp_tag.pop_front();
      chk(obs_oe === 1'b1 && obs_v === e, t, {obs_oe, obs_v}, {1'b1, e});
    end
  end

  task automatic pulse(input logic b, input bit mon);
    @(negedge clk) di = b;
    repeat (8) @(negedge clk);
    sk = 1'b1;
    repeat (6) @(negedge clk);
    if (mon) begin
      obs_v = do_o;
      obs_oe = do_oe;
      mon_pulse = 1'b1;
      #1 mon_pulse = 1'b0;
    end
    repeat (2) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) begin cs = 1'b0; di = 1'b0; end
    repeat (8) @(negedge clk);
  endtask

  task automatic head(input logic [1:0] op, input logic [8:0] a, input int nlead, input bit mon_last);
    automatic int aw = org ? 8 : 9;
    for (int i = 0; i < nlead; i++) pulse(1'b0, 0);
    pulse(1'b1, 0);
    pulse(op[1], 0);
    pulse(op[0], 0);
    for (int i = aw - 1; i >= 1; i--) pulse(a[i], 0);
    pulse(a[0], mon_last);
  endtask

  function automatic logic [7:0] get_byte(input logic [8:0] b);
    return b[0] ? model[b[8:1]][15:8] : model[b[8:1]][7:0];
  endfunction

  task automatic rd(input logic [8:0] a, input int nwords, input int nlead);
    automatic int dw = org ? 16 : 8;
    automatic logic [8:0] p = a;
    exp_val.push_back(1'b0); exp_tag.push_back("R2 dummy");
    for (int w = 0; w < nwords; w++) begin
      automatic logic [15:0] v = org ? model[p[7:0]] : {8'h00, get_byte(p)};
      for (int i = dw - 1; i >= 0; i--) begin
        exp_val.push_back(v[i]);
        exp_tag.push_back(w == 0 ? "R2 data" : "R3 stream");
      end
      p = org ? {1'b0, p[7:0] + 8'd1} : p + 9'd1;
    end
    cs_up();
    head(2'b10, a, nlead, 1);
    for (int i = 0; i < nwords * dw; i++) pulse(1'b0, 1);
    cs_down();
  endtask

  task automatic store(input logic [8:0] a, input logic [15:0] v, input logic erase, input bit upd);
    automatic int dw = org ? 16 : 8;
    cs_up();
    head(erase ? 2'b11 : 2'b01, a, 0, 0);
    if (!erase) for (int i = dw - 1; i >= 0; i--) pulse(v[i], 0);
    if (upd && model_we) begin
      if (org) model[a[7:0]] = erase ? 16'hFFFF : v;
      else if (a[0]) model[a[8:1]][15:8] = erase ? 8'hFF : v[7:0];
      else model[a[8:1]][7:0] = erase ? 8'hFF : v[7:0];
    end
  endtask

  task automatic ext(input logic [1:0] code);
    cs_up();
    head(2'b00, org ? {1'b0, code, 6'd0} : {code, 7'd0}, 0, 0);
    cs_down();
  endtask

  task automatic settle();
    cs_down();
    repeat (PROG + 200) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(do_oe === 1'b0, "R12 output off after reset", do_oe, 0);
    rd(9'd5, 1, 0);                                   // R12 zero storage

    // R5: locked after reset, no busy status
    store(9'd3, 16'hA5C3, 0, 1);
    cs_down();
    cs_up();
    repeat (8) @(negedge clk);
    chk(do_oe === 1'b0, "R5 no status when locked", do_oe, 0);
    cs_down();
    rd(9'd3, 1, 0);

    // R6 unlock, R7 write, R9/R10 busy status
    ext(2'b11);
    model_we = 1;
    store(9'd3, 16'hA5C3, 0, 1);
    cs_down();
    cs_up();
    chk(do_oe === 1'b1 && do_o === 1'b0, "R10 busy shows 0", {do_oe, do_o}, 2'b10);
    repeat (690) @(negedge clk);
    chk(do_oe === 1'b1 && do_o === 1'b0, "R9 still busy", {do_oe, do_o}, 2'b10);
    repeat (150) @(negedge clk);
    chk(do_oe === 1'b1 && do_o === 1'b1, "R10 ready shows 1", {do_oe, do_o}, 2'b11);
    pulse(1'b1, 0);
    repeat (4) @(negedge clk);
    chk(do_oe === 1'b0, "R10 start bit clears status", do_oe, 0);
    cs_down();
    chk(do_oe === 1'b0, "R11 off with cs low", do_oe, 0);

    // R10: cs raised after end shows nothing; R6 persists
    store(9'd4, 16'h1234, 0, 1);
    settle();
    cs_up();
    repeat (8) @(negedge clk);
    chk(do_oe === 1'b0, "R10 no status after end", do_oe, 0);
    cs_down();

    // R9: instruction during busy is ignored
    store(9'd5, 16'hBEEF, 0, 1);
    cs_down();
    cs_up();
    store(9'd6, 16'h1111, 0, 0);
    settle();
    rd(9'd6, 1, 0);

    store(9'd255, 16'h8001, 0, 1);
    settle();
    cs_up();
    pulse(1'b0, 0);
    pulse(1'b1, 0);
    chk(do_oe === 1'b0, "R11 off during command", do_oe, 0);
    cs_down();
    rd(9'd3, 3, 0);                                   // R2 R3 streaming
    rd(9'd255, 2, 2);                                 // R3 wrap, R1 leading zeros

    // R8 erase
    store(9'd4, 16'h0, 1, 1);
    settle();
    rd(9'd4, 1, 0);

    // R4 byte mode
    org = 1'b0;
    repeat (4) @(negedge clk);
    rd(9'd6, 3, 0);
    store(9'd11, 16'h005A, 0, 1);
    settle();
    store(9'd0, 16'h0, 1, 1);                        // R8 byte erase
    settle();
    rd(9'd10, 2, 1);
    org = 1'b1;
    repeat (4) @(negedge clk);
    rd(9'd5, 1, 0);
    rd(9'd0, 1, 0);

    // R6 lock again
    ext(2'b00);
    model_we = 0;
    store(9'd0, 16'h7777, 0, 1);
    settle();
    store(9'd3, 16'h0, 1, 1);
    settle();
    rd(9'd0, 1, 0);
    rd(9'd3, 1, 0);
    chk(model[0] == 16'h00FF && model[5] == 16'h5AEF, "R4 bench model", model[5], 16'h5AEF);

    repeat (20) @(negedge clk);
    chk(exp_val.size() == 0, "R2 all samples seen", exp_val.size(), 0);
    summary();
  end
endmodule